// File: doc/BRIEF.md
# Limited-Pointer Sharer Slot Allocator

This block keeps the sharer pointers for one directory entry in a machine whose core count is far larger than the number of pointers the entry can hold. Each pointer slot stores a core number, a mode bit that says whether the core may keep a private copy or must be served remotely, and a small locality counter. When a request arrives, the block either reuses the slot that already tracks the requesting core or picks a slot to overwrite. The choice follows a fixed order of slot states that protects cores still holding a private copy. Remote cores whose counter reaches the private caching threshold are promoted to private.

When every slot holds a core that still has a private copy, a new reader is still let in as a private sharer. The entry then enters a broadcast mode in which further private sharers are counted but not named. A write computes how many acknowledgements the coming invalidation will return. It then invalidates every other sharer, leaves broadcast mode and installs the writer. A separate release input reports a private copy leaving a cache, together with the locality the cache measured. The block uses it to mark the slot inactive and decide the slot's future mode.

Each request is answered one clock later with the slot used, the mode granted, the broadcast flag and the acknowledgement count. Moving the line's data is not part of this block.

Top module: `sharer_slot_alloc`

## Requirements
- R1: After reset all slots are empty, `rsp_valid` is 0 and broadcast mode is off. The first read from any core is placed in slot 0 as a remote sharer (`rsp_private`=0), with `rsp_bcast`=0 and `rsp_acks`=0.
- R2: A request from a core already held in a slot is answered with that slot's index, and no other slot changes its core number.
- R3: For a remote sharer, each request raises its locality counter by one. The request that brings the counter to PCT (default 4) promotes the slot to private and returns `rsp_private`=1. A newly installed core counts that first request as one. A tracked private sharer always gets `rsp_private`=1.
- R4: A read from an untracked core overwrites a slot chosen in this order. First an empty slot or an inactive remote slot (counter 0). Next an inactive private slot. Last the active remote slot with the smallest counter. Ties go to the lowest index. A slot whose private sharer is active is never chosen.
- R5: When all slots hold active private sharers, a read from an untracked core returns `rsp_slot_vld`=0, `rsp_private`=1 and `rsp_bcast`=1, and adds one to the broadcast sharer count.
- R6: A write returns in `rsp_acks` the number of active private slots other than the writer's own slot, plus the broadcast sharer count. `rsp_bcast` is 1 on a write exactly when that count was nonzero. Reads return `rsp_acks`=0, and on a read `rsp_bcast` shows whether the entry is in broadcast mode after the request.
- R7: After a write, every slot other than the writer's own slot is inactive, and remote counters restart from zero. An untracked writer takes the lowest empty or remote slot, otherwise the lowest private slot, and enters as a remote sharer. A write always returns `rsp_slot_vld`=1.
- R8: A write clears broadcast mode, so a following read reports `rsp_bcast`=0 unless it overflows again.
- R9: A release from a tracked active private sharer makes the slot inactive. The slot stays private if the reported locality is at least PCT and becomes remote otherwise. A release from an untracked core while in broadcast mode lowers the broadcast count by one. Any other release has no effect.
- R10: A release presented in the same cycle as a request is ignored.
- R11: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid`=1, and the response fields belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_core | input | CORE_W (10) | Requesting core number |
| rel_valid | input | 1 | A private copy has left a cache |
| rel_core | input | CORE_W (10) | Core that dropped its copy |
| rel_locality | input | RLOC_W (6) | Locality measured by that cache |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_slot_vld | output | 1 | The request was placed in a slot |
| rsp_slot | output | SLOT_W (3) | Slot index used |
| rsp_private | output | 1 | Requester is granted a private copy |
| rsp_bcast | output | 1 | Broadcast mode (read) / broadcast invalidation issued (write) |
| rsp_acks | output | CORE_W+1 (11) | Acknowledgements to expect for a write |

## Verification
A corrupted slot state stays hidden until a request or release touches it. It then shows up at the ports one cycle after that request. The symptoms are a wrong slot index when a new core is placed, a private grant one request too early or too late, or an acknowledgement count off by the miscounted sharers. A broadcast count left wrong after a release appears only at the next write's `rsp_acks`, or at the `rsp_bcast` of a read. For that reason the stimulus mixes releases and writes between reads, and it runs directed sequences that fill all slots with private sharers so that overflow is reached.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;

  // A remote sharer whose count (after this access) has reached the threshold
  // is handed a private copy.
  function automatic logic locality_promotes(int unsigned count_after, int unsigned pct);
    return count_after >= pct;
  endfunction

  // A departing private copy keeps its private standing only with enough use.
  function automatic logic keeps_private(int unsigned reported, int unsigned pct);
    return reported >= pct;
  endfunction

endpackage

// File: rtl/sa_lookup.sv
`timescale 1ns/1ps
module sa_lookup #(
  parameter int N  = 6,
  parameter int CW = 10,
  parameter int SW = 3
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][CW-1:0] core,
  input  logic [CW-1:0]        key,
  output logic                 hit,
  output logic [SW-1:0]        idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (vld[i] && core[i] == key) begin
        hit = 1'b1;
        idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/sa_victim.sv
`timescale 1ns/1ps
module sa_victim #(
  parameter int N  = 6,
  parameter int LW = 3,
  parameter int SW = 3
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0]         priv,
  input  logic [N-1:0][LW-1:0] cnt,
  input  logic                 wr_mode,
  output logic                 found,
  output logic [SW-1:0]        idx,
  output logic [N-1:0]         act_priv
);
  logic [N-1:0] cls_free;    // empty or inactive remote
  logic [N-1:0] cls_idlep;   // inactive private
  logic [N-1:0] cls_actr;    // active remote

  // On a write every slot is about to be invalidated, so activity is ignored.
  for (genvar g = 0; g < N; g++) begin : g_cls
    assign act_priv[g]  = vld[g] && priv[g] && (cnt[g] != '0);
    assign cls_free[g]  = wr_mode ? (!vld[g] || !priv[g])
                                  : (!vld[g] || (!priv[g] && cnt[g] == '0));
    assign cls_idlep[g] = vld[g] && priv[g] && (wr_mode || cnt[g] == '0);
    assign cls_actr[g]  = !wr_mode && vld[g] && !priv[g] && (cnt[g] != '0);
  end

  logic          f_a, f_b, f_c;
  logic [SW-1:0] i_a, i_b, i_c;
  logic [LW-1:0] best;

  always_comb begin
    f_a = 1'b0; i_a = '0;
    f_b = 1'b0; i_b = '0;
    f_c = 1'b0; i_c = '0;
    best = '1;
    for (int i = N-1; i >= 0; i--) begin
      if (cls_free[i])  begin f_a = 1'b1; i_a = SW'(i); end
      if (cls_idlep[i]) begin f_b = 1'b1; i_b = SW'(i); end
    end
    for (int i = 0; i < N; i++) begin
      if (cls_actr[i] && (!f_c || cnt[i] < best)) begin
        f_c  = 1'b1;
        i_c  = SW'(i);
        best = cnt[i];
      end
    end
  end

  assign found = f_a | f_b | f_c;
  assign idx   = f_a ? i_a : (f_b ? i_b : i_c);
endmodule

// File: rtl/sa_ackcount.sv
`timescale 1ns/1ps
module sa_ackcount #(
  parameter int N  = 6,
  parameter int LW = 3,
  parameter int SW = 3,
  parameter int AW = 11
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0]         priv,
  input  logic [N-1:0][LW-1:0] cnt,
  input  logic                 excl,
  input  logic [SW-1:0]        excl_idx,
  input  logic [AW-1:0]        extra,
  output logic [AW-1:0]        acks
);
  always_comb begin
    acks = extra;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && priv[i] && cnt[i] != '0 && !(excl && excl_idx == SW'(i)))
        acks = acks + AW'(1);
    end
  end
endmodule

// File: rtl/sharer_slot_alloc.sv
`timescale 1ns/1ps
module sharer_slot_alloc #(
  parameter int NUM_SLOTS = 6,
  parameter int CORE_W    = 10,
  parameter int PCT       = 4,
  parameter int RLOC_W    = 6,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ACK_W    = CORE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CORE_W-1:0] req_core,
  input  logic              rel_valid,
  input  logic [CORE_W-1:0] rel_core,
  input  logic [RLOC_W-1:0] rel_locality,
  output logic              rsp_valid,
  output logic              rsp_slot_vld,
  output logic [SLOT_W-1:0] rsp_slot,
  output logic              rsp_private,
  output logic              rsp_bcast,
  output logic [ACK_W-1:0]  rsp_acks
);
  import sa_pkg::*;

  localparam int N     = NUM_SLOTS;
  localparam int LOC_W = $clog2(PCT + 1);

  // slot state
  logic [N-1:0]             vld_q, vld_d;
  logic [N-1:0][CORE_W-1:0] core_q, core_d;
  logic [N-1:0]             priv_q, priv_d;
  logic [N-1:0][LOC_W-1:0]  cnt_q, cnt_d;
  logic [ACK_W-1:0]         extra_q, extra_d;   // untracked private sharers

  logic is_rd, is_wr, is_rel;
  assign is_rd  = req_valid & ~req_write;
  assign is_wr  = req_valid &  req_write;
  assign is_rel = rel_valid & ~req_valid;

  logic [CORE_W-1:0] key;
  assign key = req_valid ? req_core : rel_core;

  logic              ev_hit;
  logic [SLOT_W-1:0] hit_idx;
  sa_lookup #(.N(N), .CW(CORE_W), .SW(SLOT_W)) u_lookup (
    .vld(vld_q), .core(core_q), .key(key), .hit(ev_hit), .idx(hit_idx)
  );

  logic              ev_vfound;
  logic [SLOT_W-1:0] vic_idx;
  logic [N-1:0]      act_priv;
  sa_victim #(.N(N), .LW(LOC_W), .SW(SLOT_W)) u_victim (
    .vld(vld_q), .priv(priv_q), .cnt(cnt_q), .wr_mode(req_write),
    .found(ev_vfound), .idx(vic_idx), .act_priv(act_priv)
  );

  logic [ACK_W-1:0] ack_calc;
  sa_ackcount #(.N(N), .LW(LOC_W), .SW(SLOT_W), .AW(ACK_W)) u_ack (
    .vld(vld_q), .priv(priv_q), .cnt(cnt_q), .excl(ev_hit), .excl_idx(hit_idx),
    .extra(extra_q), .acks(ack_calc)
  );

  // named internal events
  logic ev_overflow, ev_bcast_inv;
  logic use_slot, install;
  logic [SLOT_W-1:0] tgt;
  logic              base_priv;
  logic [LOC_W-1:0]  base_cnt;
  logic [LOC_W:0]    bumped;

  logic              n_slot_vld, n_priv, n_bcast;
  logic [SLOT_W-1:0] n_slot;
  logic [ACK_W-1:0]  n_acks;

  always_comb begin
    vld_d = vld_q; core_d = core_q; priv_d = priv_q; cnt_d = cnt_q; extra_d = extra_q;
    n_slot_vld = 1'b0; n_slot = '0; n_priv = 1'b0; n_bcast = 1'b0; n_acks = '0;
    ev_overflow = 1'b0; ev_bcast_inv = 1'b0;
    use_slot = 1'b0; install = 1'b0; tgt = '0;
    base_priv = 1'b0; base_cnt = '0; bumped = '0;

    if (is_wr) begin
      for (int i = 0; i < N; i++) begin
        if (!(ev_hit && hit_idx == SLOT_W'(i))) cnt_d[i] = '0;
      end
      extra_d      = '0;
      n_acks       = ack_calc;
      n_bcast      = (extra_q != '0);
      ev_bcast_inv = n_bcast;
    end

    if (req_valid) begin
      if (ev_hit) begin
        use_slot = 1'b1; tgt = hit_idx;
      end else if (ev_vfound) begin
        use_slot = 1'b1; install = 1'b1; tgt = vic_idx;
      end else begin
        ev_overflow = 1'b1;
        extra_d     = extra_q + ACK_W'(1);
        n_priv      = 1'b1;
      end
    end

    if (use_slot) begin
      base_priv = install ? 1'b0 : priv_q[tgt];
      base_cnt  = install ? '0   : cnt_q[tgt];
      bumped    = {1'b0, base_cnt} + (LOC_W+1)'(1);
      if (base_priv || locality_promotes(int'(bumped), PCT)) begin
        priv_d[tgt] = 1'b1;
        cnt_d[tgt]  = LOC_W'(1);
        n_priv      = 1'b1;
      end else begin
        priv_d[tgt] = 1'b0;
        cnt_d[tgt]  = bumped[LOC_W-1:0];
      end
      if (install) begin
        vld_d[tgt]  = 1'b1;
        core_d[tgt] = req_core;
      end
      n_slot_vld = 1'b1;
      n_slot     = tgt;
    end

    if (is_rd) n_bcast = (extra_d != '0);

    if (is_rel) begin
      if (ev_hit && priv_q[hit_idx] && cnt_q[hit_idx] != '0) begin
        cnt_d[hit_idx]  = '0;
        priv_d[hit_idx] = keeps_private(int'(rel_locality), PCT);
      end else if (!ev_hit && extra_q != '0) begin
        extra_d = extra_q - ACK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0; core_q <= '0; priv_q <= '0; cnt_q <= '0; extra_q <= '0;
      rsp_valid <= 1'b0; rsp_slot_vld <= 1'b0; rsp_slot <= '0;
      rsp_private <= 1'b0; rsp_bcast <= 1'b0; rsp_acks <= '0;
    end else begin
      vld_q <= vld_d; core_q <= core_d; priv_q <= priv_d; cnt_q <= cnt_d; extra_q <= extra_d;
      rsp_valid    <= req_valid;
      rsp_slot_vld <= n_slot_vld;
      rsp_slot     <= n_slot;
      rsp_private  <= n_priv;
      rsp_bcast    <= n_bcast;
      rsp_acks     <= n_acks;
    end
  end
endmodule

// File: rtl/sa_checker.sv
`timescale 1ns/1ps
module sa_checker #(
  parameter int N  = 6,
  parameter int SW = 3,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_slot_vld,
  input logic [SW-1:0] rsp_slot,
  input logic          rsp_private,
  input logic          rsp_bcast,
  input logic [AW-1:0] rsp_acks,
  input logic          ev_hit,
  input logic [SW-1:0] hit_idx,
  input logic          ev_vfound,
  input logic [SW-1:0] vic_idx,
  input logic [N-1:0]  act_priv,
  input logic          ev_overflow,
  input logic          ev_bcast_inv,
  input logic [AW-1:0] extra_q
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);                                           // R11
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);                                         // R11
  AST_HIT_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_hit) |=> (rsp_slot_vld && rsp_slot == $past(hit_idx)));  // R2
  AST_VICTIM_NOT_ACTIVE_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !ev_hit && ev_vfound) |-> !act_priv[vic_idx]); // R4
  AST_OVERFLOW_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |-> (&act_priv));                                       // R5
  AST_OVERFLOW_GRANTS_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (rsp_private && rsp_bcast && !rsp_slot_vld));       // R5
  AST_READ_NO_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rsp_acks == '0));                    // R6
  AST_BCAST_INV_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bcast_inv |=> (rsp_bcast && rsp_acks != '0));                    // R6
  AST_WRITE_GETS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_slot_vld);                         // R7
  AST_WRITE_ENDS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (extra_q == '0));                      // R8
endmodule

bind sharer_slot_alloc sa_checker #(.N(NUM_SLOTS), .SW(SLOT_W), .AW(ACK_W)) u_sa_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_slot_vld(rsp_slot_vld), .rsp_slot(rsp_slot),
  .rsp_private(rsp_private), .rsp_bcast(rsp_bcast), .rsp_acks(rsp_acks),
  .ev_hit(ev_hit), .hit_idx(hit_idx), .ev_vfound(ev_vfound), .vic_idx(vic_idx),
  .act_priv(act_priv), .ev_overflow(ev_overflow), .ev_bcast_inv(ev_bcast_inv),
  .extra_q(extra_q)
);

// File: tb/test_sharer_slot_alloc.sv
`timescale 1ns/1ps
module test_sharer_slot_alloc;
  localparam int NS   = 6;
  localparam int CW   = 10;
  localparam int PCT  = 4;
  localparam int RLW  = 6;
  localparam int SLW  = 3;
  localparam int AKW  = CW + 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0, req_write = 1'b0;
  logic [CW-1:0]  req_core = '0;
  logic           rel_valid = 1'b0;
  logic [CW-1:0]  rel_core = '0;
  logic [RLW-1:0] rel_locality = '0;
  logic           rsp_valid, rsp_slot_vld, rsp_private, rsp_bcast;
  logic [SLW-1:0] rsp_slot;
  logic [AKW-1:0] rsp_acks;

  always #2 clk = ~clk;   // 250 MHz

  sharer_slot_alloc #(.NUM_SLOTS(NS), .CORE_W(CW), .PCT(PCT), .RLOC_W(RLW)) i_sharer_slot_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_core(req_core),
    .rel_valid(rel_valid), .rel_core(rel_core), .rel_locality(rel_locality),
    .rsp_valid(rsp_valid), .rsp_slot_vld(rsp_slot_vld), .rsp_slot(rsp_slot),
    .rsp_private(rsp_private), .rsp_bcast(rsp_bcast), .rsp_acks(rsp_acks)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit m_used[NS];
  int m_id[NS];
  bit m_prv[NS];
  int m_loc[NS];
  int m_over;

  // expected response
  bit e_sv, e_prv, e_bc;
  int e_slot, e_acks;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int m_where(int c);
    for (int i = 0; i < NS; i++) if (m_used[i] && m_id[i] == c) return i;
    return -1;
  endfunction

  function automatic void m_touch(int s);
    if (m_prv[s]) begin
      m_loc[s] = 1; e_prv = 1;
    end else begin
      m_loc[s] = m_loc[s] + 1;
      if (m_loc[s] >= PCT) begin m_prv[s] = 1; m_loc[s] = 1; e_prv = 1; end
    end
  endfunction

  // rank: lower is better; -1 means never chosen
  function automatic int rank_rd(int i);
    if (!m_used[i]) return 0;
    if (!m_prv[i] && m_loc[i] == 0) return 0;
    if (m_prv[i] && m_loc[i] == 0) return 1;
    if (!m_prv[i]) return 2 + m_loc[i];
    return -1;
  endfunction

  function automatic void m_read(int c);
    int s, best;
    e_sv = 0; e_slot = 0; e_prv = 0; e_acks = 0;
    s = m_where(c);
    if (s < 0) begin
      best = -1;
      for (int i = 0; i < NS; i++) begin
        if (rank_rd(i) >= 0 && (s < 0 || rank_rd(i) < best)) begin s = i; best = rank_rd(i); end
      end
      if (s >= 0) begin m_used[s] = 1; m_id[s] = c; m_prv[s] = 0; m_loc[s] = 0; end
    end
    if (s >= 0) begin m_touch(s); e_sv = 1; e_slot = s; end
    else begin m_over++; e_prv = 1; end
    e_bc = (m_over != 0);
  endfunction

  function automatic void m_write(int c);
    int s;
    e_sv = 1; e_prv = 0;
    s = m_where(c);
    e_acks = m_over;
    for (int i = 0; i < NS; i++)
      if (i != s && m_used[i] && m_prv[i] && m_loc[i] != 0) e_acks++;
    e_bc = (m_over != 0);
    m_over = 0;
    for (int i = 0; i < NS; i++) if (i != s) m_loc[i] = 0;
    if (s < 0) begin
      for (int i = NS-1; i >= 0; i--) if (!m_used[i] || !m_prv[i]) s = i;
      if (s < 0) s = 0;
      m_used[s] = 1; m_id[s] = c; m_prv[s] = 0; m_loc[s] = 0;
    end
    m_touch(s);
    e_slot = s;
  endfunction

  function automatic void m_release(int c, int loc);
    int s = m_where(c);
    if (s >= 0) begin
      if (m_prv[s] && m_loc[s] != 0) begin
        m_loc[s] = 0;
        if (loc < PCT) m_prv[s] = 0;
      end
    end else if (m_over > 0) m_over--;
  endfunction

  // one operation cycle; response checked at the next falling edge
  task automatic do_op(bit rq, bit wr, int rc, bit rl, int lc, int loc, string tag);
    @(negedge clk);
    req_valid = rq; req_write = wr; req_core = CW'(rc);
    rel_valid = rl; rel_core = CW'(lc); rel_locality = RLW'(loc);
    if (rq) begin
      if (wr) m_write(rc); else m_read(rc);
    end else if (rl) m_release(lc, loc);
    @(negedge clk);
    req_valid = 0; req_write = 0; rel_valid = 0;
    chk(tag, "rsp_valid", int'(rsp_valid), int'(rq));
    if (rq) begin
      chk(tag, "rsp_slot_vld", int'(rsp_slot_vld), int'(e_sv));
      if (e_sv) chk(tag, "rsp_slot", int'(rsp_slot), e_slot);
      chk(tag, "rsp_private", int'(rsp_private), int'(e_prv));
      chk(tag, "rsp_bcast", int'(rsp_bcast), int'(e_bc));
      chk(tag, "rsp_acks", int'(rsp_acks), e_acks);
    end
  endtask

  task automatic rd(int c, string tag);             do_op(1, 0, c, 0, 0, 0, tag); endtask
  task automatic wr(int c, string tag);             do_op(1, 1, c, 0, 0, 0, tag); endtask
  task automatic rel(int c, int loc, string tag);   do_op(0, 0, 0, 1, c, loc, tag); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; rel_valid = 0;
    for (int i = 0; i < NS; i++) begin m_used[i] = 0; m_id[i] = 0; m_prv[i] = 0; m_loc[i] = 0; end
    m_over = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "rsp_bcast after reset", int'(rsp_bcast), 0);
    chk("R1", "rsp_acks after reset", int'(rsp_acks), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int r, c, c2;
    void'($urandom(32'd24117));

    // R1 / R3: first read lands in slot 0; promotion on the PCT-th access
    do_reset();
    rd(100, "R1 first read");
    chk("R1", "first slot", int'(rsp_slot), 0);
    chk("R1", "first mode", int'(rsp_private), 0);
    rd(100, "R3 bump"); rd(100, "R3 bump");
    rd(100, "R3 promote");
    chk("R3", "promoted on 4th access", int'(rsp_private), 1);
    rd(100, "R2 tracked private");

    // R5 / R6 / R8: overflow into broadcast, then a write collects acks
    do_reset();
    for (int k = 0; k < NS; k++) for (int j = 0; j < PCT; j++) rd(10 + k, "R3 fill");
    rd(20, "R5 overflow");
    chk("R5", "overflow slot_vld", int'(rsp_slot_vld), 0);
    chk("R5", "overflow bcast", int'(rsp_bcast), 1);
    rd(21, "R5 overflow second");
    rel(21, 5, "R9 untracked release");
    rd(22, "R5 overflow again");
    wr(10, "R6 broadcast write");
    chk("R6", "acks 5 slots + 2 counted", int'(rsp_acks), 7);
    rd(23, "R8 after write");
    chk("R8", "bcast cleared", int'(rsp_bcast), 0);
    chk("R7", "inactive private slot 1 reused", int'(rsp_slot), 1);

    // R4 / R9 / R7 ordering
    do_reset();
    for (int k = 0; k < NS; k++) rd(30 + k, "R4 fill remote");
    rd(31, "R3 bump"); rd(31, "R3 bump"); rd(32, "R3 bump");
    rd(40, "R4 least local remote");
    chk("R4", "tie goes to slot 0", int'(rsp_slot), 0);
    rd(33, "R3"); rd(33, "R3"); rd(33, "R3 promote");
    rel(33, 9, "R9 keep private");
    rel(34, 9, "R9 remote release ignored");
    rd(41, "R4 inactive private");
    chk("R4", "inactive private slot 3", int'(rsp_slot), 3);
    rd(35, "R3"); rd(35, "R3"); rd(35, "R3 promote");
    rel(35, 1, "R9 demote to remote");
    rd(35, "R9 demoted reread");
    chk("R9", "demoted core remote", int'(rsp_private), 0);
    wr(40, "R7 write tracked");
    rd(42, "R4 inactive remote first");
    chk("R7", "first cleared remote slot 1", int'(rsp_slot), 1);
    wr(50, "R7 untracked write");

    // R10: release alongside a request is dropped
    do_reset();
    for (int j = 0; j < PCT; j++) rd(60, "R3 build");
    do_op(1, 0, 61, 1, 60, 0, "R10 simultaneous");
    wr(62, "R10 writer sees active private");
    chk("R10", "acks keep released core", int'(rsp_acks), 1);

    // randomized mix
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      r  = $urandom % 100;
      c  = 200 + ($urandom % 11);
      c2 = 200 + ($urandom % 11);
      if (r < 55)      rd(c, "R4 random read");
      else if (r < 63) wr(c, "R7 random write");
      else if (r < 95) rel(c, $urandom % 8, "R9 random release");
      else             do_op(1, r[0], c, 1, c2, $urandom % 8, "R10 random overlap");
    end

    finish_up();
  end
endmodule